// File: doc/BRIEF.md
# Handshake-to-Arbitrated Memory Bus Bridge

This block connects a processor that speaks a plain read/write handshake to a shared SRAM bus. Other agents also use that bus, and a central arbiter decides who may drive it. The processor raises a read or a write line together with a byte address and, for a write, a data word. While the bridge does the work, the processor is held stalled through a wait line. The bridge raises an active-low bus request and waits until the arbiter answers with an active-low grant. It then issues a single-cycle strobe with an active-low write-select and puts the registered word address and data on the bus. For a read, it captures the returned word in an input register.

The SRAM is word addressed. The bridge therefore drops the two byte-offset bits of the processor address and sends the next 24 bits as the word address. The arbiter may withdraw the grant in the cycle in which the strobe would be issued. In that case the bridge sends no strobe, keeps requesting and retries once the grant comes back.

Top module: `memBusBridge`

## Requirements
- R1: After reset, busReqN, busStrobeN and busWriteSelN are high and cpuWait is low.
- R2: A new read or write request is accepted when it is sampled at a clock edge while the bridge is idle. cpuWait is high combinationally in the cycle of the request. busReqN goes low in the cycle after that edge.
- R3: busStrobeN goes low only in the cycle after busGrantN was sampled low while requesting. It stays low for exactly one cycle per access.
- R4: busWriteSelN is low only during the strobe cycle of a write. It stays high for reads.
- R5: busAddr equals cpuAddr bits 25 down to 2, and busDataOut equals the write word. Both are captured when the request is accepted and stay stable while busReqN is low.
- R6: For a read, the word on busDataIn during the strobe cycle appears on cpuDataIn from the next cycle onwards. It is held unchanged across later writes until the next read.
- R7: cpuWait stays high from the request until the strobe. It goes low for exactly one cycle, the cycle right after the strobe.
- R8: busReqN returns high in the cycle after the one in which cpuWait was low.
- R9: After a completed access, no new access starts until both cpuRead and cpuWrite have been sampled low. While the bridge is idle and a request line is still held, busReqN stays high and cpuWait stays low.
- R10: If busGrantN is high in the cycle after it was sampled low, no strobe is issued in that cycle. The bridge keeps busReqN low and issues the strobe only after a fresh grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRead | input | 1 | Processor read request |
| cpuWrite | input | 1 | Processor write request |
| cpuAddr | input | 32 | Processor byte address |
| cpuDataOut | input | 32 | Write data from the processor |
| cpuWait | output | 1 | Stall to the processor, high while the transfer is pending |
| cpuDataIn | output | 32 | Registered read data to the processor |
| busReqN | output | 1 | Active-low bus request to the arbiter |
| busGrantN | input | 1 | Active-low bus grant from the arbiter |
| busStrobeN | output | 1 | Active-low access strobe |
| busWriteSelN | output | 1 | Active-low write select |
| busAddr | output | 24 | Registered word address |
| busDataOut | output | 32 | Registered write data |
| busDataIn | input | 32 | Read data from the SRAM |

## Verification
The assertions check the bus ordering on every cycle. A strobe lasts a single cycle and always follows a held request. A strobe never appears while the grant is high. Write-select is confined to the strobe cycle. The wait line drops right after each strobe, the request is released after that, and the address and data stay stable while the request is held. Only the bench scenarios can show the values that move through the bridge and their timing against the processor. These are the word-address translation, the captured read word and its retention across writes, a grant withdrawn just before the strobe, and the refusal of a request line that is held high after completion.

// File: rtl/memBridgePkg.sv
package memBridgePkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQUEST  = 3'd1,
    ST_ACCESS   = 3'd2,
    ST_COMPLETE = 3'd3,
    ST_RELEASE  = 3'd4
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;   // capture processor address / write word
    logic loadIn;    // capture word returned by the SRAM
  } ctrlStrobes_t;

endpackage

// File: rtl/memBridgeCtrl.sv
module memBridgeCtrl
  import memBridgePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuRead,
  input  logic         cpuWrite,
  input  logic         busGrantN,
  output logic         cpuWait,
  output logic         busReqN,
  output logic         busStrobeN,
  output logic         busWriteSelN,
  output ctrlStrobes_t strobes
);

  bridgeState_t state, stateNext;
  logic isWrite;
  logic armed;
  logic anyReq;
  logic accept;
  logic granted;

  assign anyReq  = cpuRead | cpuWrite;
  assign accept  = (state == ST_IDLE) && anyReq && armed;
  assign granted = ~busGrantN;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (accept) stateNext = ST_REQUEST;
      ST_REQUEST:  if (granted) stateNext = ST_ACCESS;
      ST_ACCESS:   stateNext = granted ? ST_COMPLETE : ST_REQUEST;
      ST_COMPLETE: stateNext = ST_RELEASE;
      ST_RELEASE:  stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      armed   <= 1'b1;
    end else begin
      state <= stateNext;
      if (accept) isWrite <= cpuWrite;
      if (state == ST_COMPLETE) armed <= 1'b0;
      else if (!anyReq) armed <= 1'b1;
    end
  end

  logic strobeOn;
  assign strobeOn = (state == ST_ACCESS) && granted;

  always_comb begin
    busReqN      = ~((state == ST_REQUEST) || (state == ST_ACCESS) || (state == ST_COMPLETE));
    busStrobeN   = ~strobeOn;
    busWriteSelN = ~(strobeOn && isWrite);
    unique case (state)
      ST_IDLE:     cpuWait = anyReq && armed;
      ST_REQUEST,
      ST_ACCESS:   cpuWait = 1'b1;
      ST_COMPLETE: cpuWait = 1'b0;
      ST_RELEASE:  cpuWait = anyReq;
      default:     cpuWait = 1'b0;
    endcase
    strobes.loadOut = accept;
    strobes.loadIn  = strobeOn && !isWrite;
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobeN |=> busStrobeN);
  a_r3_strobe_after_req: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobeN |-> $past(!busReqN));
  a_r4_wrsel_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busWriteSelN |-> !busStrobeN);
  a_r7_wait_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobeN |=> !cpuWait);
  a_r8_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqN && !cpuWait) |=> busReqN);
  a_r10_no_strobe_ungranted: assert property (@(posedge clk) disable iff (!rstN)
    busGrantN |-> busStrobeN);

endmodule

// File: rtl/memBridgeDatapath.sv
module memBridgeDatapath
  import memBridgePkg::*;
#(
  parameter int CPU_ADDR_W = 32,
  parameter int BUS_ADDR_W = 24,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]     cpuDataOut,
  input  logic [DATA_W-1:0]     busDataIn,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busDataOut,
  output logic [DATA_W-1:0]     cpuDataIn
);

  localparam int BYTE_OFF = $clog2(DATA_W / 8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr    <= '0;
      busDataOut <= '0;
      cpuDataIn  <= '0;
    end else begin
      if (strobes.loadOut) begin
        busAddr    <= cpuAddr[BYTE_OFF +: BUS_ADDR_W];
        busDataOut <= cpuDataOut;
      end
      if (strobes.loadIn) cpuDataIn <= busDataIn;
    end
  end

endmodule

// File: rtl/memBusBridge.sv
module memBusBridge
  import memBridgePkg::*;
#(
  parameter int CPU_ADDR_W = 32,
  parameter int BUS_ADDR_W = 24,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuRead,
  input  logic                  cpuWrite,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]     cpuDataOut,
  output logic                  cpuWait,
  output logic [DATA_W-1:0]     cpuDataIn,
  output logic                  busReqN,
  input  logic                  busGrantN,
  output logic                  busStrobeN,
  output logic                  busWriteSelN,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busDataOut,
  input  logic [DATA_W-1:0]     busDataIn
);

  ctrlStrobes_t strobes;

  memBridgeCtrl ctrl (
    .clk(clk), .rstN(rstN), .cpuRead(cpuRead), .cpuWrite(cpuWrite),
    .busGrantN(busGrantN), .cpuWait(cpuWait), .busReqN(busReqN),
    .busStrobeN(busStrobeN), .busWriteSelN(busWriteSelN), .strobes(strobes)
  );

  memBridgeDatapath #(
    .CPU_ADDR_W(CPU_ADDR_W), .BUS_ADDR_W(BUS_ADDR_W), .DATA_W(DATA_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .cpuDataOut(cpuDataOut), .busDataIn(busDataIn), .busAddr(busAddr),
    .busDataOut(busDataOut), .cpuDataIn(cpuDataIn)
  );

  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqN && $past(!busReqN)) |-> ($stable(busAddr) && $stable(busDataOut)));

endmodule

// File: tb/memBusBridge_test.sv
module memBusBridge_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuRead, cpuWrite;
  logic [31:0] cpuAddr, cpuDataOut;
  logic        cpuWait;
  logic [31:0] cpuDataIn;
  logic        busReqN, busGrantN, busStrobeN, busWriteSelN;
  logic [23:0] busAddr;
  logic [31:0] busDataOut, busDataIn;

  int checks = 0;
  int errors = 0;
  logic [31:0] lastRead = 32'h0;
  logic        done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  memBusBridge uut (
    .clk(clk), .rstN(rstN), .cpuRead(cpuRead), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuDataOut(cpuDataOut), .cpuWait(cpuWait),
    .cpuDataIn(cpuDataIn), .busReqN(busReqN), .busGrantN(busGrantN),
    .busStrobeN(busStrobeN), .busWriteSelN(busWriteSelN), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataIn(busDataIn)
  );

  function automatic logic [23:0] wordAddr(input logic [31:0] a);
    return a[25:2];
  endfunction

  function automatic logic [31:0] memWord(input logic [23:0] wa);
    return {wa[7:0], ~wa[15:8], wa} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doXfer(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                        input int delay, input logic drop);
    logic [31:0] rd;
    @(negedge clk);
    cpuRead = ~wr; cpuWrite = wr; cpuAddr = addr; cpuDataOut = data; busGrantN = 1'b1;
    #0.1;
    chk("R2 wait in request cycle", {31'b0, cpuWait}, 32'd1);
    @(negedge clk);
    cpuAddr = ~addr; cpuDataOut = ~data;  // changes must not reach the bus
    chk("R2 busReqN low", {31'b0, busReqN}, 32'd0);
    chk("R3 no strobe before grant", {31'b0, busStrobeN}, 32'd1);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk("R3 no strobe while ungranted", {31'b0, busStrobeN}, 32'd1);
      chk("R7 wait held", {31'b0, cpuWait}, 32'd1);
    end
    busGrantN = 1'b0;
    @(negedge clk);
    if (drop) begin
      busGrantN = 1'b1;
      #0.1;
      chk("R10 no strobe after grant removed", {31'b0, busStrobeN}, 32'd1);
      @(negedge clk);
      chk("R10 still requesting", {31'b0, busReqN}, 32'd0);
      chk("R10 no strobe on retry", {31'b0, busStrobeN}, 32'd1);
      chk("R10 wait held", {31'b0, cpuWait}, 32'd1);
      busGrantN = 1'b0;
      @(negedge clk);
    end
    rd = memWord(wordAddr(addr));
    busDataIn = rd;
    #0.1;
    chk("R3 strobe issued", {31'b0, busStrobeN}, 32'd0);
    chk("R4 write select", {31'b0, busWriteSelN}, {31'b0, ~wr});
    chk("R5 word address", {8'b0, busAddr}, {8'b0, wordAddr(addr)});
    if (wr) chk("R5 write data", busDataOut, data);
    chk("R7 wait during strobe", {31'b0, cpuWait}, 32'd1);
    @(negedge clk);
    busDataIn = $urandom;
    busGrantN = 1'b1;
    #0.1;
    if (!wr) lastRead = rd;
    chk("R3 strobe single cycle", {31'b0, busStrobeN}, 32'd1);
    chk("R7 wait low after strobe", {31'b0, cpuWait}, 32'd0);
    chk("R6 read data", cpuDataIn, lastRead);
    cpuRead = 1'b0; cpuWrite = 1'b0;
    @(negedge clk);
    chk("R8 request dropped", {31'b0, busReqN}, 32'd1);
    chk("R7 wait low once", {31'b0, cpuWait}, 32'd0);
    @(negedge clk);
    chk("R6 data held", cpuDataIn, lastRead);
  endtask

  initial begin
    rstN = 1'b0; cpuRead = 0; cpuWrite = 0; cpuAddr = 0; cpuDataOut = 0;
    busGrantN = 1'b1; busDataIn = 32'h0;
    void'($urandom(1502));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 busReqN", {31'b0, busReqN}, 32'd1);
    chk("R1 strobe", {31'b0, busStrobeN}, 32'd1);
    chk("R1 write select", {31'b0, busWriteSelN}, 32'd1);
    chk("R1 wait", {31'b0, cpuWait}, 32'd0);

    doXfer(1'b0, 32'hFFFF_FFFC, 32'h0, 0, 1'b0);
    doXfer(1'b1, 32'h0000_0007, 32'hDEAD_BEEF, 2, 1'b0);
    doXfer(1'b0, 32'h0123_4566, 32'h0, 1, 1'b1);
    doXfer(1'b1, 32'h0ABC_DEF1, 32'h1234_5678, 0, 1'b1);

    // R9: read line held high past completion
    @(negedge clk);
    cpuRead = 1'b1; cpuAddr = 32'h40; busGrantN = 1'b0;
    @(negedge clk); @(negedge clk);
    busDataIn = memWord(wordAddr(32'h40));
    @(negedge clk);
    chk("R9 first access completes", {31'b0, cpuWait}, 32'd0);
    lastRead = memWord(wordAddr(32'h40));
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no new request while line held", {31'b0, busReqN}, 32'd1);
      chk("R9 wait low while line held", {31'b0, cpuWait}, 32'd0);
      chk("R9 no strobe", {31'b0, busStrobeN}, 32'd1);
    end
    cpuRead = 1'b0; busGrantN = 1'b1;
    @(negedge clk);
    doXfer(1'b0, 32'h0000_0100, 32'h0, 0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      logic wr;
      wr = $urandom_range(0, 1);
      doXfer(wr, $urandom, $urandom, $urandom_range(0, 3), ($urandom_range(0, 4) == 0));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule